// File: doc/BRIEF.md
# Two-Contact Pushbutton Debounce Latch

This block cleans up a changeover pushbutton that has two contacts: one that sets and one that clears. It works the way a cross-coupled set/clear latch does. The first closure seen on either contact moves the stored bit. Any further chatter on that contact finds the bit already in that position, so it has no effect. Both contacts are asynchronous to the clock, so each one passes through its own synchroniser chain before it is used.

After a set, a hold timer counts a programmable number of clock cycles. When the count runs out, the bit clears by itself, so a deliberate second press on the set contact registers as a new event. The hold time also serves as the window that ignores bounce: it has to be longer than the worst contact chatter, which can last tens of milliseconds. The default is 0.5 s at 200 MHz. Closing the clear contact ends the hold at once. Closing both contacts together is invalid: the block keeps its state and raises a flag for as long as that condition lasts.

Top module: `bounce_latch`

## Requirements
- R1: Both contact inputs are active low (0 = closed). When the set contact alone is closed, `q_o` becomes 1 and `qn_o` becomes 0.
- R2: When the clear contact alone is closed, `q_o` becomes 0. This takes effect even while an auto-clear is pending, and it stops the hold timer.
- R3: When neither contact is closed, `q_o` keeps its previous value.
- R4: Set-contact pulses that arrive while `q_o` is 1 neither change `q_o` nor extend the hold time.
- R5: `q_o` stays 1 for exactly `HOLD_CYCLES` rising edges after a set and then returns to 0 by itself. A later press of the set contact sets it again.
- R6: When both contacts are closed, `q_o` keeps its value and `invalid_o` is 1. `invalid_o` returns to 0 once the condition ends.
- R7: `qn_o` is always the inverse of `q_o`. The two are never equal, including during the invalid condition.
- R8: A synchronous reset (`rst` = 1) forces `q_o` to 0, `qn_o` to 1 and `invalid_o` to 0, and clears the hold timer, on the next rising edge.
- R9: A change on a contact pin reaches `q_o` and `invalid_o` on the third rising edge after it is applied: two synchroniser stages and one state register.
- R10: After a clear-contact closure has stopped a pending hold, `q_o` stays 0 for as long as no contact is closed. The next set is then timed over a full `HOLD_CYCLES` from its own event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_n_i | input | 1 | Set contact, active low, asynchronous |
| clr_n_i | input | 1 | Clear contact, active low, asynchronous |
| q_o | output | 1 | Latched state |
| qn_o | output | 1 | Complement of the latched state |
| invalid_o | output | 1 | Both contacts closed at once |

## Verification
Every contact-driven result is due on the third rising edge after the pin changes. The bench applies inputs on a falling edge, counts exactly three rising edges and samples on the next falling edge. For the auto-clear, it counts edges from the set event and samples one edge before and one edge after the `HOLD_CYCLES` boundary, so an off-by-one in either direction is caught. Reset acts on the first edge, so the bench samples at the falling edge that follows that edge.

// File: rtl/bl_pkg.sv
package bl_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_SET  = 2'd1,
        CMD_CLR  = 2'd2,
        CMD_BAD  = 2'd3
    } bl_cmd_e;

    typedef struct packed {
        logic q;
        logic qn;
        logic bad;
    } bl_state_t;

    localparam bl_state_t BL_STATE_RST = '{q: 1'b0, qn: 1'b1, bad: 1'b0};

    function automatic bl_cmd_e bl_decode(input logic set_n, input logic clr_n);
        unique case ({set_n, clr_n})
            2'b11:   return CMD_IDLE;
            2'b01:   return CMD_SET;
            2'b10:   return CMD_CLR;
            default: return CMD_BAD;
        endcase
    endfunction

endpackage

// File: rtl/bl_sync.sv
module bl_sync #(
    parameter int unsigned STAGES = 2,
    parameter logic        IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE}};
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/bl_hold_timer.sv
module bl_hold_timer #(
    parameter int unsigned HOLD = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    output logic expire,
    output logic running
);
    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt;

    assign expire = running && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (stop || expire) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (running) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt < CW'(HOLD)));                        // R5
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> !running);                        // R2
endmodule

// File: rtl/bl_latch_core.sv
module bl_latch_core
    import bl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bl_cmd_e   cmd,
    input  logic      expire,
    output logic      start,
    output logic      stop,
    output bl_state_t st
);
    bl_state_t nxt;

    assign start = (cmd == CMD_SET) && !st.q;
    assign stop  = (cmd == CMD_CLR);

    always_comb begin
        nxt     = st;
        nxt.bad = (cmd == CMD_BAD);
        if (expire) begin
            nxt.q = 1'b0;
        end else begin
            unique case (cmd)
                CMD_SET:  nxt.q = 1'b1;
                CMD_CLR:  nxt.q = 1'b0;
                default:  nxt.q = st.q;
            endcase
        end
        nxt.qn = ~nxt.q;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= BL_STATE_RST;
        else     st <= nxt;
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SET && !expire) |=> st.q);                 // R1
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CLR) |=> !st.q);                           // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_IDLE && !expire) |=> $stable(st.q));       // R3
    AST_BAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_BAD && !expire) |=> ($stable(st.q) && st.bad)); // R6
    AST_BAD_DROP: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_BAD) |=> !st.bad);                         // R6
    AST_RST_STATE: assert property (@(posedge clk)
        rst |=> (!st.q && st.qn && !st.bad));                  // R8
endmodule

// File: rtl/bounce_latch.sv
module bounce_latch
    import bl_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 100_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic set_n_i,
    input  logic clr_n_i,
    output logic q_o,
    output logic qn_o,
    output logic invalid_o
);
    localparam int unsigned N_CONTACTS = 2;

    logic [N_CONTACTS-1:0] raw_n;
    logic [N_CONTACTS-1:0] clean_n;
    bl_cmd_e   cmd;
    bl_state_t st;
    logic      start, stop, expire, running;

    assign raw_n = {set_n_i, clr_n_i};

    for (genvar g = 0; g < N_CONTACTS; g++) begin : g_sync
        bl_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_n[g]),
            .dout(clean_n[g])
        );
    end

    assign cmd = bl_decode(clean_n[1], clean_n[0]);

    bl_latch_core u_core (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .expire(expire),
        .start (start),
        .stop  (stop),
        .st    (st)
    );

    bl_hold_timer #(.HOLD(HOLD_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .stop   (stop),
        .expire (expire),
        .running(running)
    );

    assign q_o       = st.q;
    assign qn_o      = st.qn;
    assign invalid_o = st.bad;

    AST_COMPL: assert property (@(posedge clk) disable iff (rst)
        q_o != qn_o);                                          // R7
    AST_TIMER_TRACKS: assert property (@(posedge clk) disable iff (rst)
        q_o == running);                                       // R4
endmodule

// File: tb/tb_bounce_latch.sv
module tb_bounce_latch;
    localparam int unsigned HOLD = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_n = 1'b1;
    logic clr_n = 1'b1;
    logic q, qn, inv;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bounce_latch #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .set_n_i(set_n), .clr_n_i(clr_n),
        .q_o(q), .qn_o(qn), .invalid_o(inv)
    );

    // {set_n, clr_n, exp_q, exp_inv, req[3:0]}
    localparam int NV = 11;
    localparam logic [7:0] VEC [0:NV-1] = '{
        {4'b1100, 4'd3},   // R3 idle after reset
        {4'b0110, 4'd1},   // R1 set
        {4'b1110, 4'd3},   // R3 hold high
        {4'b0011, 4'd6},   // R6 both closed, keeps 1
        {4'b1110, 4'd6},   // R6 flag drops
        {4'b1000, 4'd2},   // R2 clear
        {4'b1100, 4'd3},   // R3 hold low
        {4'b0001, 4'd6},   // R6 both closed, keeps 0
        {4'b1000, 4'd2},   // R2 clear after invalid
        {4'b0110, 4'd1},   // R1 set again
        {4'b1000, 4'd2}    // R2 clear to finish
    };

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_compl(input string req);
        chk(req, "qn_o inverse", qn, ~q);
    endtask

    task automatic measure(input bit bounce, input string tag);
        set_n = 1'b0;
        edges(2);
        chk("R9", "q before third edge", q, 1'b0);
        set_n = 1'b1;
        edges(1);
        chk("R9", "q at third edge", q, 1'b1);
        for (int i = 0; i < int'(HOLD) - 1; i++) begin
            if (bounce && i < 12) set_n = i[0];
            edges(1);
        end
        set_n = 1'b1;
        chk(tag, "q one edge before hold end", q, 1'b1);
        edges(1);
        chk(tag, "q at hold end", q, 1'b0);
        chk_compl("R7");
    endtask

    initial begin
        #(5 * 100_000);
        bad++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        edges(3);
        chk("R8", "q in reset", q, 1'b0);
        chk("R8", "qn in reset", qn, 1'b1);
        chk("R8", "invalid in reset", inv, 1'b0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            set_n = VEC[k][7];
            clr_n = VEC[k][6];
            edges(3);
            total++;
            if (q !== VEC[k][5] || inv !== VEC[k][4]) begin
                bad++;
                $display("FAIL R%0d vec %0d actual=q%0b/inv%0b expected=q%0b/inv%0b",
                         VEC[k][3:0], k, q, inv, VEC[k][5], VEC[k][4]);
            end
            chk_compl("R7");
        end
        set_n = 1'b1;
        clr_n = 1'b1;
        edges(3);

        measure(1'b0, "R5");
        edges(4);
        measure(1'b1, "R4");
        edges(4);
        measure(1'b0, "R5");

        // clear contact cuts a pending hold
        set_n = 1'b0;
        edges(3);
        chk("R1", "q after set", q, 1'b1);
        set_n = 1'b1;
        edges(8);
        clr_n = 1'b0;
        edges(2);
        clr_n = 1'b1;
        edges(1);
        chk("R2", "q cleared during hold", q, 1'b0);
        edges(HOLD + 5);
        chk("R10", "q stays low after stopped hold", q, 1'b0);
        measure(1'b0, "R10");

        // reset out of an invalid, set state
        set_n = 1'b0;
        edges(3);
        clr_n = 1'b0;
        edges(3);
        chk("R6", "invalid raised", inv, 1'b1);
        chk("R7", "outputs differ in invalid", qn, ~q);
        rst = 1'b1;
        set_n = 1'b1;
        clr_n = 1'b1;
        edges(1);
        chk("R8", "q after reset", q, 1'b0);
        chk("R8", "qn after reset", qn, 1'b1);
        chk("R8", "invalid after reset", inv, 1'b0);
        rst = 1'b0;
        edges(HOLD + 2);
        chk("R8", "q stays low after reset", q, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule